// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Register

This block is a serial scan chain placed around a group of bidirectional pads. For every pad it holds three scan cells: one for the value arriving from the pad, one for the core's output-enable, and one for the core's output value. Each cell has two flops. The first is a capture/shift flop, which either loads the live parallel signal or takes the bit from its upstream neighbour. The second is an update flop, which holds a stable copy that can be driven onto the pad.

The block has no TAP state machine of its own. A TAP controller outside the block supplies already-decoded strobes, all sampled on one clock:
- `dr_en` advances the capture/shift stage.
- `shift_sel` chooses shifting rather than capturing.
- `upd_en` copies the capture stage into the update stage.
- `test_mode` switches the pads, and the value returned to the core, from their normal sources to the update flops.

With `test_mode` low the chain can sample and preload without disturbing normal operation. With `test_mode` high the preloaded values drive the pads, which is external-test operation.

The serial path is not valid/ready. A bit moves on every clock in which `dr_en` and `shift_sel` are both high. The block applies no back-pressure, and the controller is the only pacing source.

Top module: `pscan_chain`

## Requirements
- R1: While `rst_n` is low, every capture and update flop is cleared to 0. After reset, `scan_out` is 0, and in test mode every `pad_oe` bit and every `core_in` bit is 0.
- R2: On a clock with `dr_en`=1 and `shift_sel`=0, each pad p loads its three capture flops. Chain cell 3p gets `pin_in[p]`, cell 3p+1 gets `core_oe[p]`, and cell 3p+2 gets `core_out[p]`.
- R3: On a clock with `dr_en`=1 and `shift_sel`=1, every capture flop takes the value of the cell below it, and cell 0 takes `scan_in`. `scan_out` always shows the top cell, 3*NUM_PINS-1. After a capture, bits therefore leave in this order: pad N-1 output, pad N-1 enable, pad N-1 input, then pad N-2, and so on.
- R4: On a clock with `dr_en`=0, the capture flops keep their values whatever `shift_sel` and `scan_in` are.
- R5: On a clock with `upd_en`=1, every update flop takes the value its capture flop held before that edge. This also holds when a shift happens in the same cycle.
- R6: On a clock with `upd_en`=0, the update flops hold, so in test mode `pad_out`, `pad_oe` and `core_in` stay stable during shifting and capturing.
- R7: With `test_mode`=0, `pad_out`=`core_out`, `pad_oe`=`core_oe` and `core_in`=`pin_in`, whatever the chain holds.
- R8: With `test_mode`=1, for each pad p: `pad_oe[p]` is update cell 3p+1, `pad_out[p]` is update cell 3p+2, and `core_in[p]` is update cell 3p.
- R9: With `test_mode`=1, a pad whose enable update cell is 0 has `pad_oe[p]`=0 (released, high impedance), whatever its output update cell holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all flops sample on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of capture and update flops |
| dr_en | input | 1 | Enables the capture/shift stage for this edge |
| shift_sel | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| upd_en | input | 1 | Copies the capture stage into the update stage on this edge |
| test_mode | input | 1 | 1 drives pads and core input from the update stage |
| scan_in | input | 1 | Serial input into cell 0 |
| scan_out | output | 1 | Serial output from the top cell |
| pin_in | input | NUM_PINS | Values received from the pads |
| core_out | input | NUM_PINS | Output values from the core |
| core_oe | input | NUM_PINS | Output enables from the core |
| pad_out | output | NUM_PINS | Value driven toward each pad |
| pad_oe | output | NUM_PINS | Drive enable for each pad; 0 means high impedance |
| core_in | output | NUM_PINS | Value handed back to the core from each pad |

## Verification
The chain is captured from several distinct pad and core patterns. The pattern bits were chosen so that each pad's three signals differ, which exposes any swap of cell kinds or wrong chain order in the bit sequence on `scan_out`. Two different serial words with mixed ones and zeros are shifted in, then updated and applied in test mode. This separates the enable cell from the output cell and shows pads being released when their enable is 0. Stretches with `dr_en` low, shifting without update, and a combined shift-and-update cycle tell apart a chain that holds correctly from one that leaks new data onto the pads. Switching back to normal mode with a loaded chain checks that the core signals pass through untouched.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  // Role of a cell inside one pad's triplet; the value is its offset in the chain.
  typedef enum logic [1:0] {
    CELL_IN  = 2'd0,
    CELL_OE  = 2'd1,
    CELL_OUT = 2'd2
  } cell_kind_e;

  localparam int CELLS_PER_PIN = 3;
endpackage

// File: rtl/pscan_cell.sv
module pscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic dr_en,
  input  logic shift_sel,
  input  logic upd_en,
  input  logic ser_in,
  input  logic par_in,
  output logic cap_q,
  output logic upd_q
);
  logic cap_d;

  // Serial neighbour when shifting, live signal when capturing.
  always_comb cap_d = shift_sel ? ser_in : par_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= 1'b0;
    else if (dr_en)  cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_q <= 1'b0;
    else if (upd_en) upd_q <= cap_q;
  end

  // R3: shift takes the upstream bit
  p_shift_takes_upstream_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_en && shift_sel) |=> cap_q == $past(ser_in));

  // R2: capture takes the parallel signal
  p_capture_parallel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_en && !shift_sel) |=> cap_q == $past(par_in));

  // R4: stage frozen without enable
  p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_en |=> $stable(cap_q));

  // R5: update copies the pre-edge capture value
  p_update_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> upd_q == $past(cap_q));

  // R6: update stage holds otherwise
  p_update_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upd_q));
endmodule

// File: rtl/pscan_pin_slice.sv
module pscan_pin_slice
  import pscan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dr_en,
  input  logic shift_sel,
  input  logic upd_en,
  input  logic test_mode,
  input  logic ser_in,
  output logic ser_out,
  input  logic pin_in,
  input  logic core_out,
  input  logic core_oe,
  output logic pad_out,
  output logic pad_oe,
  output logic core_in
);
  logic [CELLS_PER_PIN:0]   link;
  logic [CELLS_PER_PIN-1:0] par;
  logic [CELLS_PER_PIN-1:0] upd;

  assign link[0] = ser_in;
  assign ser_out = link[CELLS_PER_PIN];

  for (genvar k = 0; k < CELLS_PER_PIN; k++) begin : g_cell
    localparam cell_kind_e KIND = cell_kind_e'(k);
    if (KIND == CELL_IN) begin : g_in
      assign par[k] = pin_in;
    end else if (KIND == CELL_OE) begin : g_oe
      assign par[k] = core_oe;
    end else begin : g_out
      assign par[k] = core_out;
    end

    pscan_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .dr_en     (dr_en),
      .shift_sel (shift_sel),
      .upd_en    (upd_en),
      .ser_in    (link[k]),
      .par_in    (par[k]),
      .cap_q     (link[k+1]),
      .upd_q     (upd[k])
    );
  end

  // Output mux per path: update stage in test mode, core signal otherwise.
  always_comb begin
    if (test_mode) begin
      pad_oe  = upd[CELL_OE];
      pad_out = upd[CELL_OUT];
      core_in = upd[CELL_IN];
    end else begin
      pad_oe  = core_oe;
      pad_out = core_out;
      core_in = pin_in;
    end
  end
endmodule

// File: rtl/pscan_chain.sv
module pscan_chain
  import pscan_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dr_en,
  input  logic                shift_sel,
  input  logic                upd_en,
  input  logic                test_mode,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] core_in
);
  localparam int CHAIN_LEN = NUM_PINS * CELLS_PER_PIN;

  logic [NUM_PINS:0] hop;

  assign hop[0]   = scan_in;
  assign scan_out = hop[NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pscan_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .dr_en     (dr_en),
      .shift_sel (shift_sel),
      .upd_en    (upd_en),
      .test_mode (test_mode),
      .ser_in    (hop[p]),
      .ser_out   (hop[p+1]),
      .pin_in    (pin_in[p]),
      .core_out  (core_out[p]),
      .core_oe   (core_oe[p]),
      .pad_out   (pad_out[p]),
      .pad_oe    (pad_oe[p]),
      .core_in   (core_in[p])
    );
  end

  // R6: pad drive stable across edges without update while in test mode
  p_pads_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !upd_en) |=> (!test_mode || ($stable(pad_oe) && $stable(pad_out) && $stable(core_in))));

  // R1: reset leaves the serial output cleared (CHAIN_LEN cells in the chain)
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> scan_out == 1'b0);

  initial begin
    if (CHAIN_LEN != NUM_PINS * 3) $error("chain length mismatch");
  end
endmodule

// File: tb/pscan_chain_bench.sv
`timescale 1ns/1ps
module pscan_chain_bench;
  localparam int N = 4;
  localparam int L = 3 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dr_en = 1'b0, shift_sel = 1'b0, upd_en = 1'b0, test_mode = 1'b0, scan_in = 1'b0;
  logic [N-1:0] pin_in = '0, core_out = '0, core_oe = '0;
  logic scan_out;
  logic [N-1:0] pad_out, pad_oe, core_in;

  always #2.5 clk = ~clk;

  pscan_chain #(.NUM_PINS(N)) u_pscan_chain (
    .clk(clk), .rst_n(rst_n), .dr_en(dr_en), .shift_sel(shift_sel),
    .upd_en(upd_en), .test_mode(test_mode), .scan_in(scan_in), .scan_out(scan_out),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  logic [L-1:0] m_cap = '0;
  logic [L-1:0] m_upd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compare scan_out with the scoreboard after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, {31'd0, scan_out}, {31'd0, e.val});
    end
  end

  // Driver: apply one cycle of strobes, advance the model, push expected serial bit.
  task automatic step(input logic d, input logic s, input logic u, input logic si, input string tag);
    logic [L-1:0] nm;
    @(negedge clk);
    dr_en = d; shift_sel = s; upd_en = u; scan_in = si;
    nm = m_cap;
    if (d) begin
      if (s) nm = {m_cap[L-2:0], si};
      else begin
        for (int p = 0; p < N; p++) begin
          nm[3*p]   = pin_in[p];
          nm[3*p+1] = core_oe[p];
          nm[3*p+2] = core_out[p];
        end
      end
    end
    if (u) m_upd = m_cap;
    m_cap = nm;
    exp_q.push_back('{val: m_cap[L-1], tag: tag});
    @(posedge clk);
    #2;
    dr_en = 1'b0; upd_en = 1'b0;
  endtask

  task automatic check_pads(input string tag);
    #1;
    for (int p = 0; p < N; p++) begin
      if (test_mode) begin
        chk({tag, " oe"}, {31'd0, pad_oe[p]}, {31'd0, m_upd[3*p+1]});
        if (m_upd[3*p+1]) chk({tag, " out"}, {31'd0, pad_out[p]}, {31'd0, m_upd[3*p+2]});
        chk({tag, " core_in"}, {31'd0, core_in[p]}, {31'd0, m_upd[3*p]});
      end else begin
        chk({tag, " oe"}, {31'd0, pad_oe[p]}, {31'd0, core_oe[p]});
        chk({tag, " out"}, {31'd0, pad_out[p]}, {31'd0, core_out[p]});
        chk({tag, " core_in"}, {31'd0, core_in[p]}, {31'd0, pin_in[p]});
      end
    end
  endtask

  task automatic shift_word(input logic [L-1:0] w, input string tag);
    for (int i = 0; i < L; i++) step(1'b1, 1'b1, 1'b0, w[i], tag);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_mode = 1'b1;
    #1;
    chk("R1 scan_out", {31'd0, scan_out}, 32'd0);
    chk("R1 pad_oe", {28'd0, pad_oe}, 32'd0);
    chk("R1 core_in", {28'd0, core_in}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: normal pass-through, two patterns
    test_mode = 1'b0;
    core_out = 4'b1010; core_oe = 4'b0110; pin_in = 4'b0011;
    check_pads("R7 p1");
    core_out = 4'b0101; core_oe = 4'b1001; pin_in = 4'b1100;
    check_pads("R7 p2");

    // R2 + R3: capture then unload; order shows in the serial stream
    core_out = 4'b1001; core_oe = 4'b0101; pin_in = 4'b0110;
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2 capture");
    shift_word(12'hA5C, "R3 unload");

    // R4: no enable, chain frozen
    for (int i = 0; i < 3; i++) step(1'b0, i[0], 1'b0, 1'b1, "R4 hold");

    // R5 + R8 + R9: update and apply in test mode
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5 update");
    test_mode = 1'b1;
    check_pads("R8 apply");
    chk("R9 released pads", {28'd0, pad_oe},
        {28'd0, m_upd[10], m_upd[7], m_upd[4], m_upd[1]});

    // R6: shift a new word without update; pads must not move
    for (int i = 0; i < L; i++) begin
      step(1'b1, 1'b1, 1'b0, i[1] ^ i[0], "R3 load2");
      check_pads("R6 steady");
    end
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2 capture in test");
    check_pads("R6 after capture");

    // R5: shift and update in the same cycle take the pre-edge value
    step(1'b1, 1'b1, 1'b1, 1'b1, "R5 shift+update");
    check_pads("R8 apply2");
    shift_word(12'h3C6, "R3 load3");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5 update3");
    check_pads("R9 apply3");

    // R7: back to normal with a loaded chain
    test_mode = 1'b0;
    core_out = 4'b0011; core_oe = 4'b1110; pin_in = 4'b1000;
    check_pads("R7 loaded");

    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule